// File: doc/BRIEF.md
# Constant-Time Tag Verify and Copy Unit

This block closes out an authenticated cipher operation once the 128-bit authentication tag has been computed. When sealing (encrypt direction) it hands the computed tag to its output register so the caller can append it to the message. When opening (decrypt direction) it checks the tag that arrived with the message against the computed one. The check covers only as many 32-bit words as the tag length needs. It visits those words in an order shuffled from a seed and ORs every word difference into one flag, so nothing stops early and the duration never depends on where the tags differ.

A run begins with a one-cycle `start` while the unit is idle. The unit captures the tags, the length, the direction and the seed. It spends a fixed number of cycles building a random permutation of the word indices with a Fisher–Yates shuffle driven by a 16-bit LFSR. It then processes one word per cycle and raises `done` for one cycle. In the decrypt direction, `mismatch` reports a failed check and stays set until the next accepted start. The shuffle masks which word is being handled at any moment. It is not a source of true randomness.

Top module: `tagcmp_unit`

## Requirements
- R1: After reset `done` and `mismatch` are 0 and `tag_out` is all zeros.
- R2: The word count n is the tag length in bytes divided by 4, rounded up. A length of 0 counts as one word, and any length above 16 counts as four words.
- R3: `done` is high for exactly one cycle, n + 3 rising edges after the edge that accepts `start`. This count does not depend on the tag data, the direction or the seed.
- R4: In the decrypt direction, `mismatch` rises together with `done` if and only if some word k < n differs between `calc_tag` and `recv_tag`. Word k sits at bits [32k+31:32k], and the comparison covers the whole word even when the tag length ends partway through it.
- R5: Words with index n or higher have no effect on `mismatch` or on `tag_out`.
- R6: In the encrypt direction, when `done` rises, `tag_out` word k equals `calc_tag` word k for every k < n. The other words are zero, and `mismatch` stays 0.
- R7: In the decrypt direction `tag_out` is all zeros when `done` rises.
- R8: `mismatch` holds its value after `done` until the edge after the next accepted start, where it returns to 0.
- R9: A `start` that arrives while a run is in progress is ignored. It produces no extra `done` and does not change the running result.
- R10: The result does not depend on the seed. A seed of zero is replaced by a fixed nonzero value, so the LFSR never locks up.
- R11: All inputs are captured on the accepting edge. Changing them during a run does not alter that run's result.
- R12: A `start` asserted in the same cycle that `done` is high is accepted and begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (taken only when idle) |
| decrypt | input | 1 | 1 = verify received tag, 0 = copy computed tag |
| tag_len | input | 5 | Tag length in bytes |
| calc_tag | input | 128 | Tag computed by the cipher |
| recv_tag | input | 128 | Tag received with the message |
| seed | input | 16 | Seed for the word-order LFSR |
| tag_out | output | 128 | Copied tag (encrypt direction) |
| done | output | 1 | One-cycle end-of-run pulse |
| mismatch | output | 1 | Tag check failed; held until next start |

## Verification
Two functions can land on the same clock cycle: the final-word step that raises `done` and loads `mismatch`, and the acceptance of a new `start`. The bench provokes this by asserting `start` in the very cycle where `done` is observed high. It then checks three things: the earlier result was reported intact, `mismatch` cleared on the next edge, and the second run finished with its own expected latency, tag and flag. A second overlap, a `start` poked while a run is still busy, is judged by the absence of any unexpected `done` and by the first run's result staying unchanged.

// File: rtl/tagcmp_pkg.sv
package tagcmp_pkg;

  typedef enum logic [1:0] {
    TC_IDLE = 2'd0,
    TC_SHUF = 2'd1,
    TC_CMP  = 2'd2
  } tc_state_e;

  // Words needed to hold len_bytes, clamped to [1, max_words]
  function automatic int unsigned words_for_len(int unsigned len_bytes,
                                                int unsigned word_bytes,
                                                int unsigned max_words);
    int unsigned w;
    w = (len_bytes + word_bytes - 1) / word_bytes;
    if (w == 0) w = 1;
    if (w > max_words) w = max_words;
    return w;
  endfunction

endpackage

// File: rtl/tagcmp_lfsr.sv
module tagcmp_lfsr #(
  parameter int             W        = 16,
  parameter logic [W-1:0]   TAPS     = 16'hB400,
  parameter logic [W-1:0]   ALT_SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         adv,
  output logic [W-1:0] state
);

  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= ALT_SEED;
    end else if (load) begin
      q <= (seed == '0) ? ALT_SEED : seed;
    end else if (adv) begin
      q <= q[0] ? ((q >> 1) ^ TAPS) : (q >> 1);
    end
  end

  assign state = q;

endmodule

// File: rtl/tagcmp_shuffle.sv
module tagcmp_shuffle #(
  parameter int NW = 4,
  parameter int IW = 2,
  parameter int RW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            init,
  input  logic            step,
  input  logic [IW-1:0]   pos,
  input  logic [IW:0]     n_words,
  input  logic [RW-1:0]   rnd,
  output logic [NW*IW-1:0] perm_flat
);

  logic [IW-1:0] perm_q [NW];
  logic [IW:0]   span;
  logic [IW-1:0] pick;
  logic          do_swap;

  // Fisher-Yates step: pick j in [0, pos], swap entries pos and j
  assign span    = {1'b0, pos} + 1'b1;
  assign pick    = IW'(rnd % RW'(span));
  assign do_swap = step && ({1'b0, pos} < n_words);

  always_ff @(posedge clk) begin
    if (rst || init) begin
      for (int k = 0; k < NW; k++) perm_q[k] <= IW'(k);
    end else if (do_swap) begin
      perm_q[pos]  <= perm_q[pick];
      perm_q[pick] <= perm_q[pos];
    end
  end

  for (genvar g = 0; g < NW; g++) begin : g_flat
    assign perm_flat[g*IW +: IW] = perm_q[g];
  end

endmodule

// File: rtl/tagcmp_accum.sv
module tagcmp_accum #(
  parameter int NW = 4,
  parameter int WW = 32,
  parameter int IW = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             dec,
  input  logic [IW-1:0]    sel,
  input  logic [NW*WW-1:0] calc_flat,
  input  logic [NW*WW-1:0] recv_flat,
  output logic [NW*WW-1:0] tag_out,
  output logic             acc_q,
  output logic             word_diff
);

  logic [WW-1:0]    calc_w;
  logic [WW-1:0]    recv_w;
  logic [NW*WW-1:0] tag_q;

  assign calc_w    = calc_flat[sel*WW +: WW];
  assign recv_w    = recv_flat[sel*WW +: WW];
  assign word_diff = dec && (|(calc_w ^ recv_w));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_q <= 1'b0;
      tag_q <= '0;
    end else if (en) begin
      if (dec) acc_q <= acc_q | word_diff;
      else     tag_q[sel*WW +: WW] <= calc_w;
    end
  end

  assign tag_out = tag_q;

endmodule

// File: rtl/tagcmp_unit.sv
module tagcmp_unit #(
  parameter int                  WORD_W    = 32,
  parameter int                  NUM_WORDS = 4,
  parameter int                  LFSR_W    = 16,
  parameter logic [LFSR_W-1:0]   LFSR_TAPS = 16'hB400,
  parameter int                  LEN_W     = $clog2(NUM_WORDS*WORD_W/8 + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic                        decrypt,
  input  logic [LEN_W-1:0]            tag_len,
  input  logic [NUM_WORDS*WORD_W-1:0] calc_tag,
  input  logic [NUM_WORDS*WORD_W-1:0] recv_tag,
  input  logic [LFSR_W-1:0]           seed,
  output logic [NUM_WORDS*WORD_W-1:0] tag_out,
  output logic                        done,
  output logic                        mismatch
);
  import tagcmp_pkg::*;

  localparam int WORD_BYTES = WORD_W / 8;
  localparam int TAG_W      = NUM_WORDS * WORD_W;
  localparam int IDX_W      = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int CNT_W      = IDX_W + 1;

  tc_state_e          state_q;
  logic [IDX_W-1:0]   pos_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   nw_q;
  logic [CNT_W-1:0]   nw_in;
  logic               dec_q;
  logic [TAG_W-1:0]   calc_q;
  logic [TAG_W-1:0]   recv_q;
  logic               done_q;
  logic               mis_q;
  logic               idle_w;
  logic               accept;
  logic [LFSR_W-1:0]  lfsr_w;
  logic [NUM_WORDS*IDX_W-1:0] perm_w;
  logic [IDX_W-1:0]   sel_w;
  logic               acc_w;
  logic               diff_w;

  assign idle_w = (state_q == TC_IDLE);
  assign accept = start && idle_w;

  always_comb begin
    nw_in = CNT_W'(words_for_len(int'(tag_len), WORD_BYTES, NUM_WORDS));
  end

  tagcmp_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS)) u_lfsr (
    .clk   (clk),
    .rst   (rst),
    .load  (accept),
    .seed  (seed),
    .adv   (state_q == TC_SHUF),
    .state (lfsr_w)
  );

  tagcmp_shuffle #(.NW(NUM_WORDS), .IW(IDX_W), .RW(LFSR_W)) u_shuf (
    .clk       (clk),
    .rst       (rst),
    .init      (accept),
    .step      (state_q == TC_SHUF),
    .pos       (pos_q),
    .n_words   (nw_q),
    .rnd       (lfsr_w),
    .perm_flat (perm_w)
  );

  assign sel_w = perm_w[cnt_q[IDX_W-1:0]*IDX_W +: IDX_W];

  tagcmp_accum #(.NW(NUM_WORDS), .WW(WORD_W), .IW(IDX_W)) u_acc (
    .clk       (clk),
    .rst       (rst),
    .clr       (accept),
    .en        (state_q == TC_CMP),
    .dec       (dec_q),
    .sel       (sel_w),
    .calc_flat (calc_q),
    .recv_flat (recv_q),
    .tag_out   (tag_out),
    .acc_q     (acc_w),
    .word_diff (diff_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TC_IDLE;
      pos_q   <= '0;
      cnt_q   <= '0;
      nw_q    <= CNT_W'(1);
      dec_q   <= 1'b0;
      calc_q  <= '0;
      recv_q  <= '0;
      done_q  <= 1'b0;
      mis_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        TC_IDLE: begin
          if (start) begin
            calc_q  <= calc_tag;
            recv_q  <= recv_tag;
            dec_q   <= decrypt;
            nw_q    <= nw_in;
            mis_q   <= 1'b0;
            cnt_q   <= '0;
            pos_q   <= IDX_W'(NUM_WORDS - 1);
            state_q <= (NUM_WORDS > 1) ? TC_SHUF : TC_CMP;
          end
        end
        TC_SHUF: begin
          if (pos_q == IDX_W'(1)) state_q <= TC_CMP;
          else                    pos_q   <= pos_q - 1'b1;
        end
        TC_CMP: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == nw_q - 1'b1) begin
            state_q <= TC_IDLE;
            done_q  <= 1'b1;
            mis_q   <= acc_w | diff_w;
          end
        end
        default: state_q <= TC_IDLE;
      endcase
    end
  end

  assign done     = done_q;
  assign mismatch = mis_q;

endmodule

// File: rtl/tagcmp_unit_chk.sv
module tagcmp_unit_chk #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 4,
  parameter int LEN_W     = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             idle,
  input logic [LEN_W-1:0] tag_len,
  input logic             done,
  input logic             mismatch
);
  import tagcmp_pkg::*;

  localparam int CW = $clog2(2*NUM_WORDS + 4) + 1;

  logic          run_q;
  logic [CW-1:0] cyc_q;
  logic [CW-1:0] exp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cyc_q <= '0;
      exp_q <= '0;
    end else if (start && idle) begin
      run_q <= 1'b1;
      cyc_q <= '0;
      exp_q <= CW'(NUM_WORDS - 1 + words_for_len(int'(tag_len), WORD_W/8, NUM_WORDS));
    end else if (done) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cyc_q <= cyc_q + 1'b1;
    end
  end

  // R3
  latency_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (run_q && (cyc_q == exp_q)));

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4
  mismatch_at_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mismatch) |-> done);

  // R8
  mismatch_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (start && idle) |=> !mismatch);

  // R8
  mismatch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mismatch && !(start && idle)) |=> mismatch);

endmodule

bind tagcmp_unit tagcmp_unit_chk #(
  .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .LEN_W(LEN_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .idle     (idle_w),
  .tag_len  (tag_len),
  .done     (done),
  .mismatch (mismatch)
);

// File: tb/tagcmp_unit_test.sv
`timescale 1ns/1ps
module tagcmp_unit_test;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         decrypt = 1'b0;
  logic [4:0]   tag_len = '0;
  logic [127:0] calc_tag = '0;
  logic [127:0] recv_tag = '0;
  logic [15:0]  seed = '0;
  logic [127:0] tag_out;
  logic         done;
  logic         mismatch;

  always #2 clk = ~clk;

  tagcmp_unit uut (
    .clk(clk), .rst(rst), .start(start), .decrypt(decrypt), .tag_len(tag_len),
    .calc_tag(calc_tag), .recv_tag(recv_tag), .seed(seed),
    .tag_out(tag_out), .done(done), .mismatch(mismatch)
  );

  typedef struct {
    int unsigned  done_cyc;
    logic [127:0] tag;
    logic         mis;
    string        req;
  } exp_t;

  exp_t        sb[$];
  int unsigned cyc = 0;
  int          n_checks = 0;
  int          n_fails = 0;

  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic int unsigned model_words(input int unsigned len);
    int unsigned w;
    w = (len + 3) / 4;
    if (w < 1) w = 1;
    if (w > 4) w = 4;
    return w;
  endfunction

  // Monitor: pop and compare every completed run
  always @(negedge clk) begin
    if (!rst && done) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9", "unexpected done", 128'd1, 128'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(cyc == e.done_cyc, "R3", {e.req, " latency"}, 128'(cyc), 128'(e.done_cyc));
        check(mismatch == e.mis, e.req, "mismatch", 128'(mismatch), 128'(e.mis));
        check(tag_out == e.tag, e.req, "tag_out", tag_out, e.tag);
      end
    end
  end

  // Driver: push expectation, start a run, optionally disturb it, wait for done
  task automatic run_op(input bit dec, input int unsigned len,
                        input logic [127:0] calc, input logic [127:0] recv,
                        input logic [15:0] sd, input string req,
                        input bit same_cycle, input bit scramble, input bit poke);
    exp_t e;
    int unsigned n;
    if (!same_cycle) @(negedge clk);
    n = model_words(len);
    e.tag = '0;
    e.mis = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (k < int'(n)) begin
        if (!dec) e.tag[k*32 +: 32] = calc[k*32 +: 32];
        else if (calc[k*32 +: 32] != recv[k*32 +: 32]) e.mis = 1'b1;
      end
    end
    e.done_cyc = cyc + 1 + 3 + n;
    e.req = req;
    sb.push_back(e);
    decrypt = dec; tag_len = 5'(len); calc_tag = calc; recv_tag = recv; seed = sd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (scramble) begin
      decrypt = ~dec; tag_len = 5'd16; calc_tag = ~calc; recv_tag = recv ^ 128'h5A; seed = ~sd;
    end
    if (poke) begin
      decrypt = ~dec; calc_tag = 128'hDEAD; recv_tag = 128'hBEEF; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
  endtask

  localparam logic [127:0] TA = 128'h0123456789ABCDEF_FEDCBA9876543210;
  localparam logic [127:0] TB = 128'hA5A5A5A5_3C3C3C3C_0F0F0F0F_C3C3C3C3;

  initial begin
    #(4 * 200000);
    n_fails++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(done == 1'b0, "R1", "done", 128'(done), 128'd0);
    check(mismatch == 1'b0, "R1", "mismatch", 128'(mismatch), 128'd0);
    check(tag_out == '0, "R1", "tag_out", tag_out, 128'd0);

    // R6 encrypt copies full tag; R2 length 16
    run_op(1'b0, 16, TA, TB, 16'h1234, "R6", 0, 0, 0);
    // R2/R5 encrypt length 5 -> two words
    run_op(1'b0, 5, TB, TA, 16'h0F0F, "R2", 0, 0, 0);
    // R2 length 0 -> one word
    run_op(1'b0, 0, TA, TA, 16'h0001, "R2", 0, 0, 0);
    // R2 length above 16 clamps to four words
    run_op(1'b0, 20, TB, TA, 16'h7777, "R2", 0, 0, 0);
    // R4/R7 decrypt equal tags
    run_op(1'b1, 16, TA, TA, 16'hBEEF, "R7", 0, 0, 0);
    // R4 decrypt single-bit difference in word 0
    run_op(1'b1, 16, TA, TA ^ 128'h1, 16'h2222, "R4", 0, 0, 0);
    // R8 mismatch held before the next start
    repeat (3) @(negedge clk);
    check(mismatch == 1'b1, "R8", "held mismatch", 128'(mismatch), 128'd1);
    // R5 difference in word 3 ignored for 12-byte tag
    run_op(1'b1, 12, TA, TA ^ {32'h8000_0000, 96'h0}, 16'h3333, "R5", 0, 0, 0);
    // R4 same difference caught for 13-byte tag (whole last word compared)
    run_op(1'b1, 13, TA, TA ^ {32'h8000_0000, 96'h0}, 16'h3333, "R4", 0, 0, 0);
    // R12 start in the same cycle as done
    run_op(1'b1, 8, TB, TB, 16'h4444, "R12", 1, 0, 0);
    // R10 seed zero, different tags in word 2
    run_op(1'b1, 16, TB, TB ^ {32'h0, 32'h10, 64'h0}, 16'h0000, "R10", 0, 0, 0);
    run_op(1'b1, 16, TB, TB ^ {32'h0, 32'h10, 64'h0}, 16'hFFFF, "R10", 0, 0, 0);
    // R11 inputs changed during run
    run_op(1'b0, 9, TA, TB, 16'h5555, "R11", 0, 1, 0);
    run_op(1'b1, 4, TA, TA, 16'h6666, "R11", 0, 1, 0);
    // R9 start while busy ignored
    run_op(1'b1, 16, TB, TB, 16'h8888, "R9", 0, 0, 1);
    run_op(1'b0, 3, TA, TB, 16'h9999, "R9", 0, 0, 1);
    // R8 next start clears mismatch
    run_op(1'b1, 16, TA, TB, 16'hAAAA, "R4", 0, 0, 0);
    @(negedge clk);
    start = 1'b1; decrypt = 1'b0; tag_len = 5'd4; calc_tag = TA;
    begin
      exp_t e;
      e.done_cyc = cyc + 1 + 3 + 1; e.tag = {96'h0, TA[31:0]}; e.mis = 1'b0; e.req = "R8";
      sb.push_back(e);
    end
    @(negedge clk);
    start = 1'b0;
    check(mismatch == 1'b0, "R8", "cleared after start", 128'(mismatch), 128'd0);
    while (!done) @(negedge clk);

    repeat (6) @(negedge clk);
    check(sb.size() == 0, "R3", "pending results", 128'(sb.size()), 128'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule